// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block produces the two pulse trains that a phase comparator compares in a frequency synthesizer. On the divider clock it runs a dual-modulus prescaler, modelled as a clock-enable counter that divides by P or P+1. A swallow counter and a main counter steer the prescaler's modulus-control line. Every output cycle spans P·N + A divider clocks and ends with one pulse on `fp`. A separate binary reference counter counts oscillator strobes and emits `fr` once every R strobes. The synthesized frequency therefore follows f_vco = (P·N + A)·f_osc / R.

The values A, N and R and the modulus-pair select come from configuration registers outside the block and are held steady while the block runs. A low level on the power-save input holds every counter at its start value. When the input returns high, a fresh output cycle begins from a known phase.

Top module: `psdiv_top`

## Requirements
- R1: The base modulus P is 2^PL when `sel_small` is 1 and 2^(PL+1) when it is 0, where PL is 5 for the low-band variant (default) and 6 for the high-band variant. While running, consecutive `fp` pulses are exactly P·N + A divider clocks apart.
- R2: Within each output cycle, `mod_ctl` is high for the first A prescaler cycles, which each last P+1 clocks, and low for the remaining N−A cycles, which each last P clocks. That gives A·(P+1) clocks of `mod_ctl` high per `fp` period. `mod_ctl` changes only on a prescaler-cycle boundary.
- R3: `fp` is high for exactly one divider clock per output cycle.
- R4: The reference counter advances only on clocks where `osc_en` is 1. `fr` pulses for one clock on every R-th strobe, so with strobes on alternate clocks the `fr` spacing is 2·R clocks.
- R5: A value of `main_n` below 3 acts as 3, and a value of `ref_r` below 3 acts as 3.
- R6: While `ps_n` is 0, `fp`, `fr` and `mod_ctl` are 0 and every counter is held at zero. After `ps_n` rises, the first `fp` comes exactly P·N + A clocks later and the first `fr` comes on the R-th strobe.
- R7: `rst` is active high and synchronous. After a reset edge, `fp`, `fr` and `mod_ctl` are 0.
- R8: With A = 0, `mod_ctl` stays low and the `fp` period is P·N clocks.
- R9: A must be smaller than the effective N whenever the block runs. A violation is flagged by an assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider clock derived from the VCO |
| rst | input | 1 | Synchronous reset, active high |
| ps_n | input | 1 | 1 = run, 0 = power save (counters held) |
| osc_en | input | 1 | Oscillator strobe, one clock wide per reference edge |
| sel_small | input | 1 | 1 selects the P = 2^PL pair, 0 selects the doubled pair |
| swallow_a | input | AW (7) | Swallow count A |
| main_n | input | NW (11) | Main count N |
| ref_r | input | RW (14) | Reference ratio R |
| fp | output | 1 | Comparison pulse, one clock per output cycle |
| fr | output | 1 | Reference pulse, one clock per R strobes |
| mod_ctl | output | 1 | Prescaler modulus control, 1 = divide by P+1 |

## Verification
The hardest state to reach is the boundary where the swallow phase hands over to the plain phase. This happens after A stretched prescaler cycles, and it shows at the ports only as the total time `mod_ctl` stays high. The stimulus reaches this boundary by setting A next to its limits, at 0 and at 127 with N = 128, and at values in between. For each setting it measures the clocks between two `fp` pulses and counts the clocks with `mod_ctl` high in that same window. Clamped ratios and half-rate oscillator strobes are reached by direct settings. Each setting starts from a power-save release, so every first-pulse latency has a known phase.

// File: rtl/psdiv_pkg.sv
package psdiv_pkg;
   typedef enum logic {
      BAND_LOW  = 1'b0,
      BAND_HIGH = 1'b1
   } band_e;

   localparam int unsigned MIN_RATIO = 3;
endpackage

// File: rtl/psdiv_prescaler.sv
module psdiv_prescaler #(
   parameter int PL = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   input  logic sel_small,
   input  logic mod_hi,
   output logic tick
);
   localparam int PW = PL + 2;
   localparam logic [PW-1:0] BASE_SMALL = PW'(1) << PL;
   localparam logic [PW-1:0] BASE_LARGE = PW'(1) << (PL + 1);

   logic [PW-1:0] pcnt;
   logic [PW-1:0] last;

   always_comb begin
      last = (sel_small ? BASE_SMALL : BASE_LARGE) + {{(PW-1){1'b0}}, mod_hi} - PW'(1);
      tick = run && (pcnt >= last);
   end

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         pcnt <= '0;
      end else if (tick) begin
         pcnt <= '0;
      end else begin
         pcnt <= pcnt + PW'(1);
      end
   end

   a_r1_pre_bound : assert property (@(posedge clk) disable iff (rst)
      run |-> (pcnt <= last));
   a_r2_mod_steady : assert property (@(posedge clk) disable iff (rst)
      (run && !tick) |=> (!run || $stable(mod_hi)));
endmodule

// File: rtl/psdiv_swallow.sv
module psdiv_swallow #(
   parameter int AW = 7,
   parameter int NW = 11
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          run,
   input  logic          tick,
   input  logic [AW-1:0] a_val,
   input  logic [NW-1:0] n_val,
   output logic          mod_hi,
   output logic          cyc_end
);
   logic [NW-1:0] ncnt;
   logic [NW-1:0] a_ext;
   logic [NW-1:0] n_last;

   always_comb begin
      a_ext   = {{(NW-AW){1'b0}}, a_val};
      n_last  = n_val - NW'(1);
      mod_hi  = run && (ncnt < a_ext);
      cyc_end = tick && (ncnt >= n_last);
   end

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         ncnt <= '0;
      end else if (tick) begin
         ncnt <= (ncnt >= n_last) ? '0 : ncnt + NW'(1);
      end
   end

   a_r9_a_below_n : assert property (@(posedge clk) disable iff (rst)
      run |-> (a_ext < n_val));
   a_r2_swallow_first : assert property (@(posedge clk) disable iff (rst)
      (run && $past(run) && $rose(mod_hi)) |-> (ncnt == '0));
endmodule

// File: rtl/psdiv_refdiv.sv
module psdiv_refdiv #(
   parameter int RW = 14
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          run,
   input  logic          osc_en,
   input  logic [RW-1:0] r_val,
   output logic          fr
);
   logic [RW-1:0] rcnt;
   logic          r_term;

   always_comb begin
      r_term = osc_en && (rcnt >= r_val - RW'(1));
   end

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         rcnt <= '0;
         fr   <= 1'b0;
      end else begin
         fr <= r_term;
         if (osc_en) begin
            rcnt <= r_term ? '0 : rcnt + RW'(1);
         end
      end
   end

   a_r4_fr_single : assert property (@(posedge clk) disable iff (rst)
      fr |=> !fr);
   a_r4_fr_on_strobe : assert property (@(posedge clk) disable iff (rst)
      fr |-> $past(osc_en));
endmodule

// File: rtl/psdiv_top.sv
module psdiv_top
   import psdiv_pkg::*;
#(
   parameter band_e BAND = BAND_LOW,
   parameter int    AW   = 7,
   parameter int    NW   = 11,
   parameter int    RW   = 14
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ps_n,
   input  logic          osc_en,
   input  logic          sel_small,
   input  logic [AW-1:0] swallow_a,
   input  logic [NW-1:0] main_n,
   input  logic [RW-1:0] ref_r,
   output logic          fp,
   output logic          fr,
   output logic          mod_ctl
);
   localparam logic [NW-1:0] N_FLOOR = NW'(MIN_RATIO);
   localparam logic [RW-1:0] R_FLOOR = RW'(MIN_RATIO);

   if (AW >= NW) begin : g_bad_aw
      $error("swallow width must be below main width");
   end
   if (NW < 2 || RW < 2) begin : g_bad_w
      $error("counter widths must hold the ratio floor");
   end

   logic          run;
   logic          tick;
   logic          cyc_end;
   logic [NW-1:0] n_eff;
   logic [RW-1:0] r_eff;

   always_comb begin
      run   = ps_n && !rst;
      n_eff = (main_n < N_FLOOR) ? N_FLOOR : main_n;
      r_eff = (ref_r  < R_FLOOR) ? R_FLOOR : ref_r;
   end

   if (BAND == BAND_LOW) begin : g_low
      psdiv_prescaler #(.PL(5)) u_pre (
         .clk(clk), .rst(rst), .run(run), .sel_small(sel_small),
         .mod_hi(mod_ctl), .tick(tick));
   end else begin : g_high
      psdiv_prescaler #(.PL(6)) u_pre (
         .clk(clk), .rst(rst), .run(run), .sel_small(sel_small),
         .mod_hi(mod_ctl), .tick(tick));
   end

   psdiv_swallow #(.AW(AW), .NW(NW)) u_swallow (
      .clk(clk), .rst(rst), .run(run), .tick(tick),
      .a_val(swallow_a), .n_val(n_eff),
      .mod_hi(mod_ctl), .cyc_end(cyc_end));

   psdiv_refdiv #(.RW(RW)) u_ref (
      .clk(clk), .rst(rst), .run(run), .osc_en(osc_en),
      .r_val(r_eff), .fr(fr));

   always_ff @(posedge clk) begin
      if (!run) begin
         fp <= 1'b0;
      end else begin
         fp <= cyc_end;
      end
   end

   a_r3_fp_single : assert property (@(posedge clk) disable iff (rst)
      fp |=> !fp);
   a_r6_ps_quiet : assert property (@(posedge clk) disable iff (rst)
      !ps_n |=> (!fp && !fr));
   a_r7_reset_quiet : assert property (@(posedge clk)
      rst |=> (!fp && !fr));
endmodule

// File: tb/psdiv_top_bench.sv
module psdiv_top_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ps_n = 1'b0;
   logic        osc_en = 1'b0;
   logic        sel_small = 1'b1;
   logic [6:0]  swallow_a = 7'd0;
   logic [10:0] main_n = 11'd10;
   logic [13:0] ref_r = 14'd10;
   logic        fp, fr, mod_ctl;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   psdiv_top u_psdiv_top (
      .clk(clk), .rst(rst), .ps_n(ps_n), .osc_en(osc_en), .sel_small(sel_small),
      .swallow_a(swallow_a), .main_n(main_n), .ref_r(ref_r),
      .fp(fp), .fr(fr), .mod_ctl(mod_ctl));

   always #4 clk = ~clk;

   // sel, A, N, R, expected fp period, expected mod_ctl clocks, expected fr period
   localparam int NV = 7;
   localparam int V_SEL[NV] = '{1, 0, 1, 1, 0, 1, 0};
   localparam int V_A  [NV] = '{5, 3, 0, 2, 127, 99, 0};
   localparam int V_N  [NV] = '{10, 4, 3, 1, 128, 200, 2};
   localparam int V_R  [NV] = '{7, 3, 20, 1, 100, 500, 0};
   localparam int V_FP [NV] = '{325, 259, 96, 98, 8319, 6499, 192};
   localparam int V_MC [NV] = '{165, 195, 0, 66, 8255, 3267, 0};
   localparam int V_FR [NV] = '{7, 3, 20, 3, 100, 500, 3};

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic run_vec(input int sel, input int a, input int n, input int r,
                          input int e_fp, input int e_mc, input int e_fr, input bit half);
      int fp_t[3];
      int fr_t[2];
      int nfp = 0, nfr = 0, mc = 0, wide = 0;
      bit prev_fp = 0, prev_fr = 0;
      int lim;
      ps_n = 1'b0;
      sel_small = sel[0];
      swallow_a = 7'(a);
      main_n = 11'(n);
      ref_r = 14'(r);
      osc_en = 1'b1;
      @(negedge clk);
      @(negedge clk);
      // R6: held in power save
      chk(!fp && !fr && !mod_ctl, "R6 ps quiet", {fp, fr, mod_ctl}, 0);
      ps_n = 1'b1;
      lim = 2 * e_fp + 4 * e_fr + 20;
      for (int cyc = 1; cyc <= lim; cyc++) begin
         osc_en = half ? cyc[0] : 1'b1;
         @(negedge clk);
         if (fp) begin
            if (prev_fp) wide++;
            if (nfp < 3) fp_t[nfp] = cyc;
            nfp++;
         end
         if (nfp == 1 && mod_ctl) mc++;
         if (fr) begin
            if (prev_fr) wide++;
            if (nfr < 2) fr_t[nfr] = cyc;
            nfr++;
         end
         prev_fp = fp;
         prev_fr = fr;
      end
      chk(nfp >= 2, "R1 fp seen", nfp, 2);
      chk(nfr >= 2, "R4 fr seen", nfr, 2);
      if (nfp >= 2) begin
         chk(fp_t[0] == e_fp, "R6 first fp", fp_t[0], e_fp);
         chk(fp_t[1] - fp_t[0] == e_fp, "R1 fp period", fp_t[1] - fp_t[0], e_fp);
         // R2 and R8: mod_ctl high clocks in one output cycle
         chk(mc == e_mc, "R2 R8 mod_ctl clocks", mc, e_mc);
      end
      if (nfr >= 2) begin
         if (!half) chk(fr_t[0] == e_fr, "R6 first fr", fr_t[0], e_fr);
         chk(fr_t[1] - fr_t[0] == (half ? 2 * e_fr : e_fr), "R4 R5 fr period",
             fr_t[1] - fr_t[0], half ? 2 * e_fr : e_fr);
      end
      chk(wide == 0, "R3 single-clock pulses", wide, 0);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      // R7: reset state
      ps_n = 1'b1;
      osc_en = 1'b1;
      repeat (3) @(negedge clk);
      chk(!fp && !fr && !mod_ctl, "R7 reset state", {fp, fr, mod_ctl}, 0);
      ps_n = 1'b0;
      @(negedge clk);
      rst = 1'b0;

      // Vector table: R1 R2 R5 R6 R8
      for (int i = 0; i < NV; i++) begin
         run_vec(V_SEL[i], V_A[i], V_N[i], V_R[i], V_FP[i], V_MC[i], V_FR[i], 1'b0);
      end

      // R4: strobes on alternate clocks double the fr spacing
      run_vec(1, 5, 10, 7, 325, 165, 7, 1'b1);

      // R6: power save mid-run silences outputs
      ps_n = 1'b0;
      sel_small = 1'b1; swallow_a = 7'd4; main_n = 11'd6; ref_r = 14'd5;
      @(negedge clk);
      ps_n = 1'b1;
      osc_en = 1'b1;
      repeat (50) @(negedge clk);
      chk(mod_ctl, "R2 mod_ctl high in swallow phase", mod_ctl, 1);
      ps_n = 1'b0;
      @(negedge clk);
      chk(!fp && !fr && !mod_ctl, "R6 ps mid-run", {fp, fr, mod_ctl}, 0);
      repeat (10) begin
         @(negedge clk);
         chk(!fp && !fr && !mod_ctl, "R6 ps held", {fp, fr, mod_ctl}, 0);
      end

      // R7: reset mid-run
      ps_n = 1'b1;
      repeat (40) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(!fp && !fr && !mod_ctl, "R7 reset mid-run", {fp, fr, mod_ctl}, 0);
      rst = 1'b0;

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule